// File: doc/BRIEF.md
# Coarse-Fine Frequency Detector Merge Stage

This block sits between two frequency detectors of a reference-less clock recovery loop and the single charge pump they share. The fine detector's increase and decrease pulses reach the outputs at all times. A registered direction bit decides which of the two coarse pulses may also reach the outputs. That bit records whether the incoming data runs faster or slower than the local clock. Coarse and fine acquisition therefore act together rather than one after the other. When the loop nears lock, the coarse detector goes quiet and the fine pulses alone steer the pump.

After reset the direction bit is low, and the block pulls the oscillator down using decrease pulses from either detector. The first coarse increase pulse seen while the block is enabled sets the bit. From then on, coarse increase pulses are merged onto the increase output and coarse decrease pulses are blocked. An enable input gates both outputs to zero. It also stops coarse increase pulses from affecting the bit. While the block is disabled, a coarse decrease pulse clears the bit again so a new search can start.

Top module: `fd_combiner`

## Requirements
- R1: While reset (rst_n low) is applied and after it is released with no pulses present, dir_o is 0 and up_o and dn_o are both 0.
- R2: With en high and dir_o equal to 0, up_o equals up_fine and dn_o equals dn_coarse OR dn_fine, except in the case covered by R5. up_coarse has no effect on the outputs in this state.
- R3: With en high and dir_o equal to 1, up_o equals up_coarse OR up_fine and dn_o equals dn_fine, except in the case covered by R5. dn_coarse has no effect on the outputs in this state.
- R4: A clock edge at which en and up_coarse are both high sets dir_o to 1. While en stays high, dir_o stays 1, whatever dn_coarse does.
- R5: up_o and dn_o are never high together. Whenever the merged increase and merged decrease terms would both be 1, for instance when up_fine and dn_fine arrive together, both outputs are 0.
- R6: While en is low, up_o and dn_o are both 0, for every combination of pulse inputs.
- R7: While en is low, up_coarse does not change dir_o. A clock edge at which en is low and dn_coarse is high clears dir_o to 0. With en low and dn_coarse low, dir_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the direction bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the outputs and the setting of the direction bit |
| up_coarse | input | 1 | Coarse detector increase pulse |
| dn_coarse | input | 1 | Coarse detector decrease pulse |
| up_fine | input | 1 | Fine detector increase pulse |
| dn_fine | input | 1 | Fine detector decrease pulse |
| up_o | output | 1 | Merged increase command to the charge pump |
| dn_o | output | 1 | Merged decrease command to the charge pump |
| dir_o | output | 1 | Direction bit: 1 when the data is faster than the clock |

## Verification
The bench builds the block with its only parameter, DIR_RESET, left at 0, so the search starts in the decrease direction. This reset value means that a vector holding all sixteen pulse patterns can be applied in that state first. Each vector is withdrawn before the next clock edge, so the coarse increase pulse in it cannot move the bit. The sixteen patterns are then repeated after a deliberate set, and finally under disable. Holding a pulse across an edge on purpose exercises the set, sticky, clear and freeze rules of the direction bit.

// File: rtl/fd_combiner.sv
module fd_combiner #(
  parameter bit DIR_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic up_coarse,
  input  logic dn_coarse,
  input  logic up_fine,
  input  logic dn_fine,
  output logic up_o,
  output logic dn_o,
  output logic dir_o
);

  logic dir_q;
  logic up_mrg, dn_mrg, clash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dir_q <= DIR_RESET;
    else if (en && up_coarse)
      dir_q <= 1'b1;
    else if (!en && dn_coarse)
      dir_q <= 1'b0;
  end

  assign up_mrg = up_fine | (dir_q & up_coarse);
  assign dn_mrg = dn_fine | (~dir_q & dn_coarse);
  assign clash  = up_mrg & dn_mrg;

  assign up_o  = en & up_mrg & ~clash;
  assign dn_o  = en & dn_mrg & ~clash;
  assign dir_o = dir_q;

endmodule

// File: rtl/fd_combiner_chk.sv
module fd_combiner_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic up_coarse,
  input logic dn_coarse,
  input logic up_o,
  input logic dn_o,
  input logic dir_o
);

  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up_coarse) |=> dir_o);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dir_o) |=> dir_o);

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o));

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!up_o && !dn_o));

  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !dn_coarse) |=> (dir_o == $past(dir_o)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && dn_coarse) |=> !dir_o);

endmodule

bind fd_combiner fd_combiner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .up_coarse(up_coarse), .dn_coarse(dn_coarse),
  .up_o(up_o), .dn_o(dn_o), .dir_o(dir_o)
);

// File: tb/tb_fd_combiner.sv
module tb_fd_combiner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, uc = 1'b0, dc = 1'b0, uf = 1'b0, df = 1'b0;
  logic up_o, dn_o, dir_o;
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fd_combiner dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .up_coarse(uc), .dn_coarse(dc), .up_fine(uf), .dn_fine(df),
    .up_o(up_o), .dn_o(dn_o), .dir_o(dir_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] ref_out(input logic d, input logic e,
      input logic u_c, input logic d_c, input logic u_f, input logic d_f);
    logic u, n;
    u = u_f | (d & u_c);
    n = d_f | (~d & d_c);
    if (u && n) return 2'b00;
    return {e & u, e & n};
  endfunction

  task automatic clr();
    uc = 0; dc = 0; uf = 0; df = 0;
  endtask

  task automatic sweep(input logic e, input logic d, input string req);
    for (int i = 0; i < 16; i++) begin
      logic [1:0] x;
      @(negedge clk);
      en = e; {uc, dc, uf, df} = i[3:0];
      #1;
      x = ref_out(d, e, uc, dc, uf, df);
      chk(req, up_o, x[1]);
      chk(req, dn_o, x[0]);
      chk("R5", up_o & dn_o, 1'b0);
      #1 clr();
    end
  endtask

  task automatic hold_edge(input logic e, input logic u_c, input logic d_c);
    @(negedge clk);
    en = e; uc = u_c; dc = d_c; uf = 0; df = 0;
    @(posedge clk); #1;
    clr();
  endtask

  task automatic t_reset();
    #2;
    chk("R1", dir_o, 1'b0);
    chk("R1", up_o, 1'b0);
    chk("R1", dn_o, 1'b0);
    @(negedge clk); rst_n = 1'b1; en = 1'b1;
    @(negedge clk);
    chk("R1", dir_o, 1'b0);
    chk("R1", up_o | dn_o, 1'b0);
  endtask

  task automatic t_dir_low();
    sweep(1'b1, 1'b0, "R2");
    chk("R2", dir_o, 1'b0);
  endtask

  task automatic t_set();
    hold_edge(1'b1, 1'b1, 1'b0);
    chk("R4", dir_o, 1'b1);
    hold_edge(1'b1, 1'b0, 1'b1);
    chk("R4", dir_o, 1'b1);
    hold_edge(1'b1, 1'b1, 1'b1);
    chk("R4", dir_o, 1'b1);
  endtask

  task automatic t_dir_high();
    sweep(1'b1, 1'b1, "R3");
    chk("R3", dir_o, 1'b1);
  endtask

  task automatic t_disable();
    sweep(1'b0, 1'b1, "R6");
    hold_edge(1'b0, 1'b0, 1'b0);
    chk("R7", dir_o, 1'b1);
    hold_edge(1'b0, 1'b0, 1'b1);
    chk("R7", dir_o, 1'b0);
    hold_edge(1'b0, 1'b1, 1'b0);
    chk("R7", dir_o, 1'b0);
    sweep(1'b0, 1'b0, "R6");
    hold_edge(1'b1, 1'b1, 1'b0);
    chk("R4", dir_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_dir_low();
    t_set();
    t_dir_high();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule